// File: doc/BRIEF.md
# Multiple Error Header Log Queue

This block keeps the header record for uncorrectable errors of a link endpoint. Each error arrives as a one-hot status vector together with up to four header dwords and four prefix dwords and two qualifiers: the header is valid, and a prefix is present. The block holds the uncorrectable status register, a first-error pointer, the logged header and prefix dwords and a flag saying a prefix was logged. When the option to record several headers is on, errors that arrive while the first logged error is still pending wait in a small queue instead of overwriting the log.

Software acts through a write port. A status write clears bits with write-one-to-clear semantics. A control write turns the multiple-header option on or off. Clearing the status bit named by the first-error pointer retires the logged error: the oldest queued record then moves into the log, or the log is zeroed if nothing waits. A push into a full queue is lost and raises a one-cycle pulse that the caller reports as a correctable header-log-overflow error. The queue depth is a parameter; a depth of zero removes the option altogether.

Top module: `hdr_log_queue`

## Requirements
- R1: An error is accepted only when `err_valid` is high and `err_status` has exactly one bit set; a zero or multi-bit vector changes neither the status, the log nor the queue.
- R2: An accepted error with status bit i sets bit i of `uncor_status` at the next clock edge; a status write clears every bit that is 1 in `stat_w1c`.
- R3: An accepted error that is not queued is logged at the next edge: `first_err_ptr` takes the index i of its status bit.
- R4: Logged header dword d (bits 32d+31..32d) is stored with its four bytes reversed in the same dword position of `hdr_log`; when `err_hdr_valid` is low, `hdr_log` becomes zero.
- R5: Prefix dwords are stored byte-reversed in the same way, and `pfx_logged` set, only when `err_pfx_present` and `e2e_pfx_en` are both high at load time; otherwise `pfx_log` is zero and `pfx_logged` is 0.
- R6: With the option on and `uncor_status` bit `first_err_ptr` set, an accepted error is appended to the queue and the log stays unchanged.
- R7: An error that would be appended to a full queue is dropped (its status bit is still set) and `hlo_pulse` is high for exactly the following cycle.
- R8: A status write that clears the bit at `first_err_ptr` while the option is on and the queue holds records moves the oldest record into the log, and the status bits of all records queued before the write, the moved one included, are set again.
- R9: A status write that clears the bit at `first_err_ptr` while the queue is empty or the option is off sets `first_err_ptr`, `pfx_logged`, `hdr_log` and `pfx_log` to zero.
- R10: A status write that leaves the bit at `first_err_ptr` set while the option is on keeps the log and sets the status bits of all queued records again.
- R11: A status write that leaves the bit at `first_err_ptr` set while the option is off empties the queue.
- R12: Within one cycle the status write acts first (including any pop) and the arriving error is then judged against the resulting status and pointer; a pop and a push in the same cycle on a full queue cause no overflow.
- R13: `mhr_capable` is 1 exactly when `DEPTH` is above 0; `mhr_enable` changes only on a control write, and with `DEPTH` 0 it stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| err_valid | input | 1 | Error record present this cycle |
| err_status | input | 32 | One-hot uncorrectable status of the error |
| err_hdr_valid | input | 1 | Header dwords are meaningful |
| err_pfx_present | input | 1 | Prefix dwords are meaningful |
| err_hdr | input | 128 | Header dwords, dword d at bits 32d+31..32d |
| err_pfx | input | 128 | Prefix dwords, same layout |
| e2e_pfx_en | input | 1 | End-to-end prefix support enabled |
| stat_wr | input | 1 | Status write strobe |
| stat_w1c | input | 32 | Bits to clear in the status register |
| ctl_wr | input | 1 | Control write strobe |
| ctl_mhr_en | input | 1 | New value of the multiple-header option |
| uncor_status | output | 32 | Uncorrectable status register |
| first_err_ptr | output | 5 | Index of the logged error's status bit |
| pfx_logged | output | 1 | Prefix log holds data |
| hdr_log | output | 128 | Logged header dwords |
| pfx_log | output | 128 | Logged prefix dwords |
| mhr_capable | output | 1 | Queue exists |
| mhr_enable | output | 1 | Multiple-header option on |
| hlo_pulse | output | 1 | Header-log overflow, one cycle |

## Verification
The status write that retires the first error and a newly arriving error can land in the same cycle, so a pop and a push compete for the queue and for the log. The bench drives that case on purpose, with the queue partly filled and again when it is full, and judges it against a behavioural model that applies the write first and then files the error against the updated pointer. A long random phase over eight low status bits makes repeated error types, clears of queued bits and such collisions common, and every cycle is compared against the model.

// File: rtl/hlq_pkg.sv
package hlq_pkg;

    localparam int STAT_W = 32;
    localparam int PTR_W  = $clog2(STAT_W);
    localparam int LOG_DW = 4;
    localparam int LOG_W  = LOG_DW * 32;

    typedef struct packed {
        logic [STAT_W-1:0] stat;
        logic              hdr_valid;
        logic              pfx_present;
        logic [LOG_W-1:0]  hdr;
        logic [LOG_W-1:0]  pfx;
    } err_rec_t;

    typedef struct packed {
        logic [PTR_W-1:0] ptr;
        logic             pfx_logged;
        logic [LOG_W-1:0] hdr;
        logic [LOG_W-1:0] pfx;
    } log_t;

    function automatic logic is_onehot(logic [STAT_W-1:0] s);
        return (s != '0) && ((s & (s - 1'b1)) == '0);
    endfunction

    function automatic logic [PTR_W-1:0] lowest_idx(logic [STAT_W-1:0] s);
        logic [PTR_W-1:0] idx;
        idx = '0;
        for (int i = STAT_W - 1; i >= 0; i--) begin
            if (s[i]) idx = PTR_W'(i);
        end
        return idx;
    endfunction

    function automatic logic [LOG_W-1:0] swap_bytes(logic [LOG_W-1:0] v);
        logic [LOG_W-1:0] o;
        for (int d = 0; d < LOG_DW; d++) begin
            for (int b = 0; b < 4; b++) begin
                o[d*32 + (3-b)*8 +: 8] = v[d*32 + b*8 +: 8];
            end
        end
        return o;
    endfunction

    function automatic log_t make_log(err_rec_t r, logic e2e);
        log_t l;
        l.ptr        = lowest_idx(r.stat);
        l.pfx_logged = r.pfx_present && e2e;
        l.hdr        = r.hdr_valid ? swap_bytes(r.hdr) : '0;
        l.pfx        = l.pfx_logged ? swap_bytes(r.pfx) : '0;
        return l;
    endfunction

endpackage

// File: rtl/hlq_fifo.sv
module hlq_fifo
    import hlq_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              push,
    input  err_rec_t          push_rec,
    input  logic              pop,
    input  logic              flush,
    output err_rec_t          head_rec,
    output logic              empty,
    output logic              full,
    output logic [STAT_W-1:0] stat_or
);
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    err_rec_t         mem [DEPTH];
    logic [IDX_W-1:0] head_q, head_n, wr_idx;
    logic [CNT_W-1:0] cnt_q, cnt_pop, cnt_n;
    logic [DEPTH-1:0] live;

    // A slot is live when its distance from the head is below the count.
    for (genvar g = 0; g < DEPTH; g++) begin : g_live
        assign live[g] = (((g >= int'(head_q)) ? (g - int'(head_q))
                                               : (g + DEPTH - int'(head_q))) < int'(cnt_q));
    end

    always_comb begin
        stat_or = '0;
        for (int k = 0; k < DEPTH; k++) begin
            if (live[k]) stat_or = stat_or | mem[k].stat;
        end
    end

    assign head_rec = mem[head_q];
    assign empty    = (cnt_q == '0);
    assign full     = (cnt_q == CNT_W'(DEPTH));

    // Pop is applied before push so a full queue can take a record in the same cycle.
    always_comb begin
        int hn, wi;
        hn      = int'(head_q) + (pop ? 1 : 0);
        head_n  = IDX_W'((hn >= DEPTH) ? hn - DEPTH : hn);
        cnt_pop = cnt_q - CNT_W'(pop);
        wi      = int'(head_n) + int'(cnt_pop);
        wr_idx  = IDX_W'((wi >= DEPTH) ? wi - DEPTH : wi);
        cnt_n   = cnt_pop + CNT_W'(push);
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            head_q <= '0;
            cnt_q  <= '0;
        end else begin
            head_q <= head_n;
            cnt_q  <= cnt_n;
        end
    end

    always_ff @(posedge clk) begin
        if (push && !flush) mem[wr_idx] <= push_rec;
    end

endmodule

// File: rtl/hlq_log.sv
module hlq_log
    import hlq_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic load,
    input  logic clr,
    input  log_t lin,
    output log_t lout
);
    always_ff @(posedge clk) begin
        if (rst) begin
            lout <= '0;
        end else if (load) begin
            lout <= lin;
        end else if (clr) begin
            lout <= '0;
        end
    end
endmodule

// File: rtl/hdr_log_queue.sv
module hdr_log_queue
    import hlq_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              err_valid,
    input  logic [STAT_W-1:0] err_status,
    input  logic              err_hdr_valid,
    input  logic              err_pfx_present,
    input  logic [LOG_W-1:0]  err_hdr,
    input  logic [LOG_W-1:0]  err_pfx,
    input  logic              e2e_pfx_en,
    input  logic              stat_wr,
    input  logic [STAT_W-1:0] stat_w1c,
    input  logic              ctl_wr,
    input  logic              ctl_mhr_en,
    output logic [STAT_W-1:0] uncor_status,
    output logic [PTR_W-1:0]  first_err_ptr,
    output logic              pfx_logged,
    output logic [LOG_W-1:0]  hdr_log,
    output logic [LOG_W-1:0]  pfx_log,
    output logic              mhr_capable,
    output logic              mhr_enable,
    output logic              hlo_pulse
);
    localparam logic CAPABLE = (DEPTH > 0);

    logic [STAT_W-1:0] stat_q, stat_a, stat_n;
    logic              en_q, ovf_q;
    logic              first_clr, pop, clr_log, flush, push, ovf;
    logic              err_ok, to_queue, log_new;
    logic [PTR_W-1:0]  ptr_a;
    err_rec_t          new_rec, q_head;
    logic              q_empty, q_full;
    logic [STAT_W-1:0] q_or;
    log_t              log_q, log_in;

    assign new_rec = '{stat: err_status, hdr_valid: err_hdr_valid,
                       pfx_present: err_pfx_present, hdr: err_hdr, pfx: err_pfx};

    // Stage A: the status write. Stage B: the arriving error, against stage A's result.
    always_comb begin
        first_clr = stat_wr && (!stat_q[log_q.ptr] || stat_w1c[log_q.ptr]);
        pop       = first_clr && en_q && !q_empty;
        clr_log   = first_clr && !pop;
        flush     = stat_wr && !first_clr && !en_q;
        stat_a    = stat_q;
        if (stat_wr) stat_a = (stat_q & ~stat_w1c) | (en_q ? q_or : '0);
        ptr_a     = pop ? lowest_idx(q_head.stat) : (clr_log ? '0 : log_q.ptr);

        err_ok    = err_valid && is_onehot(err_status);
        to_queue  = err_ok && en_q && stat_a[ptr_a];
        ovf       = to_queue && q_full && !pop;
        push      = to_queue && !ovf;
        log_new   = err_ok && !to_queue;
        stat_n    = stat_a | (err_ok ? err_status : '0);
        log_in    = log_new ? make_log(new_rec, e2e_pfx_en) : make_log(q_head, e2e_pfx_en);
    end

    if (DEPTH > 0) begin : g_queue
        hlq_fifo #(.DEPTH(DEPTH)) u_fifo (
            .clk      (clk),
            .rst      (rst),
            .push     (push),
            .push_rec (new_rec),
            .pop      (pop),
            .flush    (flush),
            .head_rec (q_head),
            .empty    (q_empty),
            .full     (q_full),
            .stat_or  (q_or)
        );
    end else begin : g_noqueue
        assign q_head  = '0;
        assign q_empty = 1'b1;
        assign q_full  = 1'b1;
        assign q_or    = '0;
    end

    hlq_log u_log (
        .clk  (clk),
        .rst  (rst),
        .load (log_new || pop),
        .clr  (clr_log),
        .lin  (log_in),
        .lout (log_q)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            stat_q <= '0;
            en_q   <= 1'b0;
            ovf_q  <= 1'b0;
        end else begin
            stat_q <= stat_n;
            ovf_q  <= ovf;
            if (ctl_wr) en_q <= ctl_mhr_en && CAPABLE;
        end
    end

    assign uncor_status  = stat_q;
    assign first_err_ptr = log_q.ptr;
    assign pfx_logged    = log_q.pfx_logged;
    assign hdr_log       = log_q.hdr;
    assign pfx_log       = log_q.pfx;
    assign mhr_capable   = CAPABLE;
    assign mhr_enable    = en_q;
    assign hlo_pulse     = ovf_q;

endmodule

// File: rtl/hlq_chk.sv
module hlq_chk
    import hlq_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              err_valid,
    input logic [STAT_W-1:0] err_status,
    input logic              e2e_pfx_en,
    input logic              stat_wr,
    input logic [STAT_W-1:0] stat_w1c,
    input logic              ctl_wr,
    input logic              ctl_mhr_en,
    input logic [STAT_W-1:0] uncor_status,
    input logic [PTR_W-1:0]  first_err_ptr,
    input logic              pfx_logged,
    input logic [LOG_W-1:0]  hdr_log,
    input logic [LOG_W-1:0]  pfx_log,
    input logic              mhr_capable,
    input logic              mhr_enable,
    input logic              hlo_pulse
);
    assert_reject_R1: assert property (@(posedge clk) disable iff (rst)
        err_valid && !is_onehot(err_status) && !stat_wr
        |=> uncor_status == $past(uncor_status) && first_err_ptr == $past(first_err_ptr));

    assert_status_set_R2: assert property (@(posedge clk) disable iff (rst)
        err_valid && is_onehot(err_status) |=> (uncor_status & $past(err_status)) != '0);

    assert_ptr_load_R3: assert property (@(posedge clk) disable iff (rst)
        err_valid && is_onehot(err_status) && !mhr_enable
        |=> first_err_ptr == lowest_idx($past(err_status)));

    assert_pfx_gate_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(pfx_logged) |-> $past(e2e_pfx_en));

    assert_queue_hold_R6: assert property (@(posedge clk) disable iff (rst)
        err_valid && is_onehot(err_status) && mhr_enable && !stat_wr && uncor_status[first_err_ptr]
        |=> $stable(first_err_ptr) && $stable(hdr_log) && $stable(pfx_log));

    assert_ovf_cause_R7: assert property (@(posedge clk) disable iff (rst)
        hlo_pulse |-> $past(err_valid && mhr_enable));

    assert_log_clear_R9: assert property (@(posedge clk) disable iff (rst)
        stat_wr && !mhr_enable && stat_w1c[first_err_ptr] && !err_valid
        |=> first_err_ptr == '0 && hdr_log == '0 && pfx_log == '0 && !pfx_logged);

    assert_log_keep_R10: assert property (@(posedge clk) disable iff (rst)
        stat_wr && mhr_enable && uncor_status[first_err_ptr] && !stat_w1c[first_err_ptr] && !err_valid
        |=> $stable(first_err_ptr) && $stable(hdr_log) && uncor_status[first_err_ptr]);

    assert_enable_src_R13: assert property (@(posedge clk) disable iff (rst)
        $rose(mhr_enable) |-> $past(ctl_wr && ctl_mhr_en));

    assert_cap_gate_R13: assert property (@(posedge clk) disable iff (rst)
        !mhr_capable |-> !mhr_enable);
endmodule

bind hdr_log_queue hlq_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .err_valid     (err_valid),
    .err_status    (err_status),
    .e2e_pfx_en    (e2e_pfx_en),
    .stat_wr       (stat_wr),
    .stat_w1c      (stat_w1c),
    .ctl_wr        (ctl_wr),
    .ctl_mhr_en    (ctl_mhr_en),
    .uncor_status  (uncor_status),
    .first_err_ptr (first_err_ptr),
    .pfx_logged    (pfx_logged),
    .hdr_log       (hdr_log),
    .pfx_log       (pfx_log),
    .mhr_capable   (mhr_capable),
    .mhr_enable    (mhr_enable),
    .hlo_pulse     (hlo_pulse)
);

// File: tb/hdr_log_queue_test.sv
module hdr_log_queue_test;
    localparam int PERIOD = 10;
    localparam int DEPTH  = 4;

    logic         clk = 1'b0;
    logic         rst;
    logic         err_valid, err_hdr_valid, err_pfx_present, e2e_pfx_en;
    logic [31:0]  err_status, stat_w1c;
    logic [127:0] err_hdr, err_pfx;
    logic         stat_wr, ctl_wr, ctl_mhr_en;

    logic [31:0]  o_stat, z_stat;
    logic [4:0]   o_ptr, z_ptr;
    logic         o_pl, z_pl, o_cap, z_cap, o_en, z_en, o_ovf, z_ovf;
    logic [127:0] o_hdr, o_pfx, z_hdr, z_pfx;

    always #(PERIOD/2) clk = ~clk;

    hdr_log_queue #(.DEPTH(DEPTH)) uut (
        .clk(clk), .rst(rst), .err_valid(err_valid), .err_status(err_status),
        .err_hdr_valid(err_hdr_valid), .err_pfx_present(err_pfx_present),
        .err_hdr(err_hdr), .err_pfx(err_pfx), .e2e_pfx_en(e2e_pfx_en),
        .stat_wr(stat_wr), .stat_w1c(stat_w1c), .ctl_wr(ctl_wr), .ctl_mhr_en(ctl_mhr_en),
        .uncor_status(o_stat), .first_err_ptr(o_ptr), .pfx_logged(o_pl),
        .hdr_log(o_hdr), .pfx_log(o_pfx), .mhr_capable(o_cap), .mhr_enable(o_en),
        .hlo_pulse(o_ovf));

    hdr_log_queue #(.DEPTH(0)) uut0 (
        .clk(clk), .rst(rst), .err_valid(err_valid), .err_status(err_status),
        .err_hdr_valid(err_hdr_valid), .err_pfx_present(err_pfx_present),
        .err_hdr(err_hdr), .err_pfx(err_pfx), .e2e_pfx_en(e2e_pfx_en),
        .stat_wr(stat_wr), .stat_w1c(stat_w1c), .ctl_wr(ctl_wr), .ctl_mhr_en(ctl_mhr_en),
        .uncor_status(z_stat), .first_err_ptr(z_ptr), .pfx_logged(z_pl),
        .hdr_log(z_hdr), .pfx_log(z_pfx), .mhr_capable(z_cap), .mhr_enable(z_en),
        .hlo_pulse(z_ovf));

    // Behavioural reference model
    typedef struct { logic [31:0] st; logic hv; logic pp; logic [127:0] h; logic [127:0] p; } rec_t;
    rec_t         mq[$];
    logic [31:0]  m_stat;
    logic [4:0]   m_ptr;
    logic         m_pl, m_en, m_ovf;
    logic [127:0] m_hdr, m_pfx;

    function automatic logic [127:0] rev(logic [127:0] v);
        logic [127:0] o;
        for (int d = 0; d < 4; d++)
            for (int b = 0; b < 4; b++)
                o[d*32 + 24 - b*8 +: 8] = v[d*32 + b*8 +: 8];
        return o;
    endfunction

    function automatic bit single(logic [31:0] s);
        return $countones(s) == 1;
    endfunction

    task automatic m_load(rec_t r);
        for (int i = 0; i < 32; i++) if (r.st[i]) begin m_ptr = 5'(i); break; end
        m_pl  = r.pp && e2e_pfx_en;
        m_hdr = r.hv ? rev(r.h) : 128'h0;
        m_pfx = m_pl ? rev(r.p) : 128'h0;
    endtask

    always @(posedge clk) begin
        if (rst) begin
            mq.delete();
            m_stat = 0; m_ptr = 0; m_pl = 0; m_en = 0; m_ovf = 0; m_hdr = 0; m_pfx = 0;
        end else begin
            logic [31:0] s;
            rec_t r;
            s = m_stat;
            m_ovf = 0;
            if (stat_wr) begin
                s = s & ~stat_w1c;
                if (!s[m_ptr]) begin
                    if (m_en && mq.size() > 0) begin
                        foreach (mq[k]) s = s | mq[k].st;
                        r = mq.pop_front();
                        m_load(r);
                    end else begin
                        m_ptr = 0; m_pl = 0; m_hdr = 0; m_pfx = 0;
                    end
                end else if (m_en) begin
                    foreach (mq[k]) s = s | mq[k].st;
                end else begin
                    mq.delete();
                end
            end
            if (err_valid && single(err_status)) begin
                r = '{err_status, err_hdr_valid, err_pfx_present, err_hdr, err_pfx};
                if (m_en && s[m_ptr]) begin
                    if (mq.size() < DEPTH) mq.push_back(r);
                    else m_ovf = 1;
                end else begin
                    m_load(r);
                end
                s = s | err_status;
            end
            m_stat = s;
            if (ctl_wr) m_en = ctl_mhr_en;
        end
    end

    int    n_checks = 0;
    int    n_fail   = 0;
    bit    done     = 0;
    string tag      = "reset";

    task automatic report();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    task automatic compare();
        n_checks++;
        if (o_stat !== m_stat || o_ptr !== m_ptr || o_pl !== m_pl || o_en !== m_en ||
            o_ovf !== m_ovf || o_hdr !== m_hdr || o_pfx !== m_pfx || o_cap !== 1'b1) begin
            n_fail++;
            $display("FAIL %s: stat=%h ptr=%0d pl=%b en=%b ovf=%b hdr=%h pfx=%h expected stat=%h ptr=%0d pl=%b en=%b ovf=%b hdr=%h pfx=%h",
                     tag, o_stat, o_ptr, o_pl, o_en, o_ovf, o_hdr, o_pfx,
                     m_stat, m_ptr, m_pl, m_en, m_ovf, m_hdr, m_pfx);
        end
        n_checks++;
        if (z_cap !== 1'b0 || z_en !== 1'b0) begin
            n_fail++;
            $display("FAIL R13 depth0: cap=%b en=%b expected cap=0 en=0", z_cap, z_en);
        end
    endtask

    task automatic idle();
        err_valid = 0; err_status = 0; err_hdr_valid = 0; err_pfx_present = 0;
        err_hdr = 0; err_pfx = 0; stat_wr = 0; stat_w1c = 0; ctl_wr = 0; ctl_mhr_en = 0;
    endtask

    task automatic tick();
        @(posedge clk);
        #(PERIOD/4);
        compare();
        idle();
    endtask

    task automatic send(logic [31:0] st, logic hv, logic pp);
        err_valid = 1; err_status = st; err_hdr_valid = hv; err_pfx_present = pp;
        err_hdr = {$urandom, $urandom, $urandom, $urandom};
        err_pfx = {$urandom, $urandom, $urandom, $urandom};
    endtask

    task automatic wr_stat(logic [31:0] m);
        stat_wr = 1; stat_w1c = m;
    endtask

    task automatic wr_ctl(logic en);
        ctl_wr = 1; ctl_mhr_en = en;
    endtask

    initial begin
        #(PERIOD * 100000);
        n_fail++;
        $display("FAIL watchdog: run did not complete, actual=hung expected=finished");
        report();
    end

    initial begin
        idle();
        e2e_pfx_en = 0;
        rst = 1;
        repeat (3) @(posedge clk);
        #(PERIOD/4);
        rst = 0;
        tag = "reset"; compare();

        tag = "R3 R2 log with option off";  send(32'h8, 1, 0);  tick();
        tag = "R4 header not valid";        send(32'h20, 0, 0); tick();
        tag = "R5 prefix without e2e";      send(32'h40, 1, 1); tick();
        e2e_pfx_en = 1;
        tag = "R5 prefix with e2e";         send(32'h80, 1, 1); tick();
        tag = "R1 zero vector";             send(32'h0, 1, 1);  tick();
        tag = "R1 two-bit vector";          send(32'h30, 1, 1); tick();
        tag = "R2 clear other bit";         wr_stat(32'h40);    tick();
        tag = "R9 clear first, option off"; wr_stat(32'h80);    tick();
        tag = "R2 clear all";               wr_stat('1);        tick();
        tag = "R13 enable option";          wr_ctl(1);          tick();

        tag = "R6 first logged";            send(32'h4, 1, 1);  tick();
        for (int i = 9; i <= 12; i++) begin
            tag = "R6 queued";              send(32'h1 << i, 1, 1); tick();
        end
        tag = "R7 overflow";                send(32'h2000, 1, 0); tick();
        tag = "R7 pulse ends";              tick();
        tag = "R10 first kept, reassert";   wr_stat(32'h600); tick();
        tag = "R8 pop on clear";            wr_stat(32'h4);   tick();
        tag = "R12 pop and push";           wr_stat(32'h200); send(32'h4000, 1, 1); tick();
        tag = "R12 fill";                   send(32'h8000, 0, 1); tick();
        tag = "R12 full pop and push";      wr_stat(32'h400); send(32'h10000, 1, 0); tick();
        tag = "R12 no pulse";               tick();
        tag = "R11 disable";                wr_ctl(0);        tick();
        tag = "R11 flush";                  wr_stat(32'h100000); tick();
        tag = "R11 enable";                 wr_ctl(1);        tick();
        tag = "R11 clear after flush";      wr_stat('1);      tick();
        tag = "R9 empty queue clear";       send(32'h2, 1, 1); tick();
        wr_stat(32'h2); tick();

        tag = "R12 random mix";
        for (int c = 0; c < 3000; c++) begin
            int k;
            k = $urandom_range(0, 99);
            if (k < 55) begin
                if (k < 5) send($urandom & 32'hff, $urandom, $urandom);
                else       send(32'h1 << $urandom_range(0, 7), $urandom, $urandom);
            end
            if ($urandom_range(0, 99) < 20) wr_stat($urandom & 32'hff);
            if ($urandom_range(0, 99) < 4)  wr_ctl($urandom_range(0, 3) != 0);
            if ($urandom_range(0, 99) < 10) e2e_pfx_en = ~e2e_pfx_en;
            tick();
        end
        report();
    end
endmodule